// File: doc/BRIEF.md
# Dual-Rate Token-Bucket Transmit Shaper

This block polices the traffic leaving one node of a transmit hierarchy. It holds two token buckets. The committed bucket measures conformance to a guaranteed rate. The peak bucket measures conformance to a ceiling rate. Each bucket is programmed with one 64-bit word. The word carries a refill amount and a burst cap, both written as a mantissa with an implicit offset of 256 and a power-of-two exponent. It also carries a divider exponent that stretches the refill period. Credit is kept in units of 1/256 byte. Once every refill period, an enabled bucket gains its refill amount, and the credit is clamped at its cap.

The sender presents a packet length and reads back a colour at once, with no clock delay. Green means the committed bucket covers the packet. Yellow means only the peak bucket covers it. Red means neither bucket covers it. When the sender commits to the packet, it asserts the grant together with the request. The length is then taken from every enabled bucket. The base refill period depends on the node's level. A top-level node has a shorter period and no peak bucket at all.

Top module: `dual_bucket_shaper`

## Requirements
- R1: The configuration word has the following fields:
  - enable at bit 0;
  - refill mantissa at bits 8:1;
  - refill exponent at bits 12:9;
  - divider exponent at bits 16:13;
  - cap mantissa at bits 36:29;
  - cap exponent at bits 40:37.

  A bucket is active only when its enable bit is 1 and its divider exponent is at most 12.
- R2: An active bucket adds ((256 + refill mantissa) << refill exponent) credit units once every (base_ticks << divider exponent) clocks. The first addition lands on the clock edge that comes that many edges after the configuration write.
- R3: An active bucket's credit never exceeds its cap, which is (256 + cap mantissa) << (cap exponent + 1) units. That cap equals ((256 + cap mantissa) << (cap exponent + 1)) / 256 bytes.
- R4: A configuration write loads the bucket with its full cap and restarts its refill counter. A write that leaves the bucket inactive clears its credit. After reset, both buckets are inactive.
- R5: The colour output is combinational and uses the code green = 0, yellow = 1, red = 2. A bucket covers a packet when its credit is at least length × 256 units. The colour is green when the committed bucket covers the packet. It is yellow when only the peak bucket covers it. It is red when neither does.
- R6: An inactive bucket covers every length.
- R7: When both request valid and grant are high on an edge, the length × 256 units is subtracted from every active bucket. Credit saturates at −(2^LEN_W − 1) × 256 units. A grant without request valid changes nothing.
- R8: A top-level node uses a base period of 240 clocks and has no peak bucket. Writes to its peak bucket have no effect, and a packet that the committed bucket does not cover is red.
- R9: Every node that is not top level uses a base period of 860 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_peak | input | 1 | Selects the bucket to write: 0 = committed, 1 = peak |
| cfg_word | input | 64 | Configuration word (fields as in R1) |
| req_valid | input | 1 | A packet length is presented |
| req_len | input | LEN_W | Packet length in bytes |
| tx_grant | input | 1 | The packet is being sent; debit the buckets |
| colour | output | 2 | Conformance colour for req_len (code as in R5) |

## Verification
The hardest state to reach is a bucket whose debt has been clamped at the negative floor. Many granted packets can drive credit below zero. The floor only shows once refill brings the credit back up to a known point. To reach it, the test programs a refill of exactly 2^22 units per period and grants three maximum-length packets right after the write. At the first refill the credit must then come to exactly one byte, and the test samples the colour on the edges just before and just after that refill. The same exact-edge sampling also checks the divider stretch, the 240-clock top-level period and the restart of the refill counter on a rewrite.

// File: rtl/shaper_pkg.sv
package shaper_pkg;

   localparam int unsigned CFG_W    = 64;
   localparam int unsigned MAN_W    = 8;
   localparam int unsigned EXP_W    = 4;
   localparam int unsigned DIV_W    = 4;
   localparam int unsigned DIV_MAX  = 12;

   // bit positions inside the configuration word
   localparam int unsigned POS_EN   = 0;
   localparam int unsigned POS_RMAN = 1;
   localparam int unsigned POS_REXP = 9;
   localparam int unsigned POS_DIV  = 13;
   localparam int unsigned POS_BMAN = 29;
   localparam int unsigned POS_BEXP = 37;

   typedef struct packed {
      logic [EXP_W-1:0] bexp;
      logic [MAN_W-1:0] bman;
      logic [DIV_W-1:0] dexp;
      logic [EXP_W-1:0] rexp;
      logic [MAN_W-1:0] rman;
      logic             en;
   } rate_cfg_t;

   typedef enum logic [1:0] {
      CLR_GREEN  = 2'd0,
      CLR_YELLOW = 2'd1,
      CLR_RED    = 2'd2
   } colour_t;

   function automatic rate_cfg_t unpack_cfg(input logic [CFG_W-1:0] w);
      rate_cfg_t c;
      c.en   = w[POS_EN];
      c.rman = w[POS_RMAN +: MAN_W];
      c.rexp = w[POS_REXP +: EXP_W];
      c.dexp = w[POS_DIV  +: DIV_W];
      c.bman = w[POS_BMAN +: MAN_W];
      c.bexp = w[POS_BEXP +: EXP_W];
      return c;
   endfunction

   function automatic logic cfg_usable(input rate_cfg_t c);
      return c.en && (c.dexp <= DIV_W'(DIV_MAX));
   endfunction

endpackage

// File: rtl/shaper_wheel.sv
module shaper_wheel #(
   parameter int unsigned BASE_TICKS = 860,
   parameter int unsigned DIV_MAX    = 12,
   parameter int unsigned DIV_W      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             run,
   input  logic [DIV_W-1:0] div_exp,
   output logic             tick
);
   localparam int unsigned CNT_W = $clog2(BASE_TICKS) + DIV_MAX + 1;

   if (BASE_TICKS < 2) begin : g_bad_ticks
      $error("shaper_wheel: BASE_TICKS must be at least 2");
   end
   if ((1 << DIV_W) <= DIV_MAX) begin : g_bad_div
      $error("shaper_wheel: DIV_W too narrow for DIV_MAX");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last_cnt;

   assign last_cnt = (CNT_W'(BASE_TICKS) << div_exp) - CNT_W'(1);
   assign tick     = run && (cnt_q == last_cnt);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || !run || tick) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assert_wheel_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (cnt_q == '0));

   assert_wheel_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> (cnt_q <= last_cnt));

endmodule

// File: rtl/shaper_bucket.sv
module shaper_bucket
   import shaper_pkg::*;
#(
   parameter int unsigned LEN_W      = 14,
   parameter int unsigned BASE_TICKS = 860
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic [CFG_W-1:0] cfg_word,
   input  logic [LEN_W-1:0] req_len,
   input  logic             ded_en,
   output logic             conform
);
   localparam int unsigned CAP_W  = MAN_W + 1 + (1 << EXP_W);
   localparam int unsigned LEN_UW = LEN_W + 8 + 1;
   localparam int unsigned CRED_W = ((CAP_W > LEN_UW) ? CAP_W : LEN_UW) + 2;
   localparam logic signed [CRED_W-1:0] MAX_LEN_UNITS =
      $signed(CRED_W'(((64'd1 << LEN_W) - 64'd1) << 8));
   localparam logic signed [CRED_W-1:0] FLOOR = -MAX_LEN_UNITS;

   function automatic logic signed [CRED_W-1:0] scaled(
      input logic [MAN_W-1:0] man, input logic [EXP_W:0] sh);
      return $signed(CRED_W'({1'b1, man}) << sh);
   endfunction

   rate_cfg_t cfg_q;
   rate_cfg_t cfg_new;
   logic      active;
   logic      tick;
   logic signed [CRED_W-1:0] credit_q;
   logic signed [CRED_W-1:0] credit_d;
   logic signed [CRED_W-1:0] cap_units;
   logic signed [CRED_W-1:0] add_units;
   logic signed [CRED_W-1:0] len_units;
   logic signed [CRED_W-1:0] load_units;

   assign cfg_new    = unpack_cfg(cfg_word);
   assign active     = cfg_usable(cfg_q);
   assign cap_units  = scaled(cfg_q.bman, {1'b0, cfg_q.bexp} + 5'd1);
   assign add_units  = scaled(cfg_q.rman, {1'b0, cfg_q.rexp});
   assign len_units  = $signed(CRED_W'(req_len) << 8);
   assign load_units = cfg_usable(cfg_new) ?
                       scaled(cfg_new.bman, {1'b0, cfg_new.bexp} + 5'd1) : '0;

   shaper_wheel #(
      .BASE_TICKS (BASE_TICKS),
      .DIV_MAX    (DIV_MAX),
      .DIV_W      (DIV_W)
   ) u_wheel (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (cfg_wr),
      .run     (active),
      .div_exp (cfg_q.dexp),
      .tick    (tick)
   );

   always_comb begin
      credit_d = credit_q;
      if (tick) begin
         credit_d = credit_d + add_units;
         if (credit_d > cap_units) credit_d = cap_units;
      end
      if (ded_en) begin
         credit_d = credit_d - len_units;
         if (credit_d < FLOOR) credit_d = FLOOR;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q    <= '0;
         credit_q <= '0;
      end else if (cfg_wr) begin
         cfg_q    <= cfg_new;
         credit_q <= load_units;
      end else if (active) begin
         credit_q <= credit_d;
      end
   end

   assign conform = !active || (credit_q >= len_units);

   assert_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (credit_q <= cap_units));

   assert_floor_R7: assert property (@(posedge clk) disable iff (!rst_n)
      credit_q >= FLOOR);

   assert_idle_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!active && !cfg_wr) |=> $stable(credit_q));

   assert_gain_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !cfg_wr && !tick) |=> (credit_q <= $past(credit_q)));

   assert_load_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_usable(cfg_new)) |=> (credit_q == cap_units));

endmodule

// File: rtl/shaper_colour.sv
module shaper_colour
   import shaper_pkg::*;
#(
   parameter bit HAS_PEAK = 1'b1
) (
   input  logic    c_ok,
   input  logic    p_ok,
   output colour_t colour
);
   if (HAS_PEAK) begin : g_two
      always_comb begin
         if (c_ok)      colour = CLR_GREEN;
         else if (p_ok) colour = CLR_YELLOW;
         else           colour = CLR_RED;
      end
   end else begin : g_one
      logic unused_p;
      assign unused_p = p_ok;
      assign colour   = c_ok ? CLR_GREEN : CLR_RED;
   end
endmodule

// File: rtl/dual_bucket_shaper.sv
module dual_bucket_shaper
   import shaper_pkg::*;
#(
   parameter int unsigned LEN_W       = 14,
   parameter bit          TOP_LEVEL   = 1'b0,
   parameter int unsigned TOP_TICKS   = 240,
   parameter int unsigned OTHER_TICKS = 860
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_wr,
   input  logic             cfg_peak,
   input  logic [CFG_W-1:0] cfg_word,
   input  logic             req_valid,
   input  logic [LEN_W-1:0] req_len,
   input  logic             tx_grant,
   output logic [1:0]       colour
);
   localparam int unsigned WHEEL = TOP_LEVEL ? TOP_TICKS : OTHER_TICKS;

   if (LEN_W < 1 || LEN_W > 20) begin : g_bad_len
      $error("dual_bucket_shaper: LEN_W must lie in 1..20");
   end

   logic    send;
   logic    c_ok;
   logic    p_ok;
   colour_t col;

   assign send = req_valid && tx_grant;

   shaper_bucket #(.LEN_W(LEN_W), .BASE_TICKS(WHEEL)) u_commit (
      .clk      (clk),
      .rst_n    (rst_n),
      .cfg_wr   (cfg_wr && !cfg_peak),
      .cfg_word (cfg_word),
      .req_len  (req_len),
      .ded_en   (send),
      .conform  (c_ok)
   );

   if (!TOP_LEVEL) begin : g_peak
      shaper_bucket #(.LEN_W(LEN_W), .BASE_TICKS(WHEEL)) u_peak (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_wr   (cfg_wr && cfg_peak),
         .cfg_word (cfg_word),
         .req_len  (req_len),
         .ded_en   (send),
         .conform  (p_ok)
      );
   end else begin : g_no_peak
      assign p_ok = 1'b0;
   end

   shaper_colour #(.HAS_PEAK(!TOP_LEVEL)) u_colour (
      .c_ok   (c_ok),
      .p_ok   (p_ok),
      .colour (col)
   );

   assign colour = col;

   assert_colour_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
      colour != 2'b11);

   if (TOP_LEVEL) begin : g_top_chk
      assert_no_yellow_R8: assert property (@(posedge clk) disable iff (!rst_n)
         colour != CLR_YELLOW);
   end

endmodule

// File: tb/dual_bucket_shaper_test.sv
module dual_bucket_shaper_test;
   localparam int LEN_W = 14;
   localparam int MAXL  = (1 << LEN_W) - 1;
   localparam logic [1:0] G = 2'd0, Y = 2'd1, R = 2'd2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #10 clk = ~clk;

   logic             cfg_wr = 0, cfg_peak = 0, req_valid = 0, tx_grant = 0;
   logic [63:0]      cfg_word = '0;
   logic [LEN_W-1:0] req_len = '0;
   logic [1:0]       colour;

   logic             t_cfg_wr = 0, t_cfg_peak = 0, t_req_valid = 0, t_tx_grant = 0;
   logic [63:0]      t_cfg_word = '0;
   logic [LEN_W-1:0] t_req_len = '0;
   logic [1:0]       t_colour;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 0;

   dual_bucket_shaper #(.LEN_W(LEN_W), .TOP_LEVEL(1'b0)) uut (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_peak(cfg_peak),
      .cfg_word(cfg_word), .req_valid(req_valid), .req_len(req_len),
      .tx_grant(tx_grant), .colour(colour));

   dual_bucket_shaper #(.LEN_W(LEN_W), .TOP_LEVEL(1'b1)) uut_top (
      .clk(clk), .rst_n(rst_n), .cfg_wr(t_cfg_wr), .cfg_peak(t_cfg_peak),
      .cfg_word(t_cfg_word), .req_valid(t_req_valid), .req_len(t_req_len),
      .tx_grant(t_tx_grant), .colour(t_colour));

   function automatic logic [63:0] mk(input int en, input int dv, input int re,
                                      input int rm, input int be, input int bm);
      return (64'(be) << 37) | (64'(bm) << 29) | (64'(dv) << 13) |
             (64'(re) << 9) | (64'(rm) << 1) | 64'(en);
   endfunction

   task automatic wcfg(input bit top, input bit peak, input logic [63:0] w);
      @(negedge clk);
      if (top) begin t_cfg_wr = 1; t_cfg_peak = peak; t_cfg_word = w; end
      else     begin cfg_wr = 1;   cfg_peak = peak;   cfg_word = w;   end
      @(negedge clk);
      t_cfg_wr = 0; cfg_wr = 0;
   endtask

   task automatic grant(input bit top, input int len, input bit valid);
      if (top) begin t_req_valid = valid; t_req_len = len[LEN_W-1:0]; t_tx_grant = 1; end
      else     begin req_valid = valid;   req_len = len[LEN_W-1:0];   tx_grant = 1;   end
      @(negedge clk);
      t_tx_grant = 0; t_req_valid = 0; tx_grant = 0; req_valid = 0;
   endtask

   task automatic edges(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic probe(input bit top, input int len, input logic [1:0] exp, input string req);
      logic [1:0] got;
      if (top) t_req_len = len[LEN_W-1:0]; else req_len = len[LEN_W-1:0];
      #1;
      got = top ? t_colour : colour;
      n_checks++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s len=%0d colour=%0d expected=%0d", req, len, got, exp);
      end
   endtask

   // R6: after reset both buckets are inactive and every length is green
   task automatic t_reset;
      probe(0, 0, G, "R4 reset");
      probe(0, MAXL, G, "R6 reset inactive");
      probe(1, MAXL, G, "R6 reset inactive top");
   endtask

   // R1: field positions, enable bit, divider range
   task automatic t_fields;
      wcfg(0, 1, 64'd0);
      wcfg(0, 0, mk(1, 12, 0, 0, 3, 3));   // cap 259<<4 = 4144 units
      probe(0, 16, G, "R1 cap fields");
      probe(0, 17, Y, "R1 cap fields");
      wcfg(0, 0, mk(1, 13, 0, 0, 0, 0));
      probe(0, MAXL, G, "R1 divider 13 inactive");
      wcfg(0, 0, mk(0, 0, 0, 0, 0, 0) | (64'd1 << 29));
      probe(0, MAXL, G, "R1 enable clear");
   endtask

   // R5 / R7: colour rule, debit of both buckets, grant without valid
   task automatic t_colour_debit;
      wcfg(0, 1, mk(1, 12, 0, 0, 3, 0));   // peak 16 bytes
      wcfg(0, 0, mk(1, 12, 0, 0, 0, 0));   // committed 2 bytes
      probe(0, 2, G, "R5 green");
      probe(0, 3, Y, "R5 yellow");
      probe(0, 16, Y, "R5 yellow edge");
      probe(0, 17, R, "R5 red");
      grant(0, 10, 1);                     // committed -8B, peak 6B
      probe(0, 1, Y, "R7 committed debited");
      probe(0, 6, Y, "R7 peak debited");
      probe(0, 7, R, "R7 peak debited");
      grant(0, 6, 0);
      probe(0, 6, Y, "R7 grant without valid");
   endtask

   // R6: inactive committed bucket conforms for every length
   task automatic t_inactive;
      wcfg(0, 1, mk(1, 12, 0, 0, 0, 0));
      wcfg(0, 0, 64'd0);
      probe(0, MAXL, G, "R6 inactive conforms");
      grant(0, MAXL, 1);
      probe(0, MAXL, G, "R6 inactive after grant");
      wcfg(0, 0, mk(1, 12, 0, 0, 0, 0));
      probe(0, 3, R, "R7 active peak was debited");
   endtask

   // R2 / R3: refill amount and divider stretch, then cap saturation
   task automatic t_refill;
      wcfg(0, 1, 64'd0);
      wcfg(0, 0, mk(1, 1, 1, 8'h80, 2, 0)); // +768 per 1720 clocks, cap 8B
      grant(0, 8, 1);
      edges(1718);
      probe(0, 3, Y, "R2 before refill");
      edges(1);
      probe(0, 3, G, "R2 refill amount");
      probe(0, 4, Y, "R2 refill amount");
      edges(5 * 1720);
      probe(0, 8, G, "R3 capped");
      probe(0, 9, Y, "R3 capped");
   endtask

   // R9 / R4: base period 860 and counter restart on rewrite
   task automatic t_period;
      wcfg(0, 0, mk(1, 0, 0, 0, 0, 0));
      grant(0, 2, 1);
      edges(858);
      probe(0, 1, Y, "R9 before 860");
      edges(1);
      probe(0, 1, G, "R9 at 860");
      probe(0, 2, Y, "R9 at 860");
      grant(0, 1, 1);
      probe(0, 1, Y, "R4 drained");
      wcfg(0, 0, mk(1, 0, 0, 0, 0, 0));
      probe(0, 2, G, "R4 reload full");
      grant(0, 2, 1);
      edges(858);
      probe(0, 1, Y, "R4 wheel restarted");
      edges(1);
      probe(0, 1, G, "R4 wheel restarted");
   endtask

   // R7: debt saturates at the floor
   task automatic t_floor;
      wcfg(0, 0, mk(1, 0, 14, 0, 0, 0));   // +2^22 units per period
      grant(0, MAXL, 1);
      grant(0, MAXL, 1);
      grant(0, MAXL, 1);
      edges(856);
      probe(0, 1, Y, "R7 floor before refill");
      edges(1);
      probe(0, 1, G, "R7 floor refill");
      probe(0, 2, Y, "R7 floor refill");
   endtask

   // R8: top level period 240, peak ignored, red without yellow
   task automatic t_top;
      wcfg(1, 1, mk(1, 0, 15, 255, 15, 255));
      wcfg(1, 0, mk(1, 0, 0, 0, 0, 0));
      probe(1, 2, G, "R8 top green");
      probe(1, 3, R, "R8 top peak ignored");
      grant(1, 2, 1);
      edges(238);
      probe(1, 1, R, "R8 before 240");
      edges(1);
      probe(1, 1, G, "R8 at 240");
   endtask

   initial begin
      #(20 * 200000);
      if (!done) begin
         n_fail++;
         n_checks++;
         $display("FAIL watchdog expired");
         $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      edges(3);
      rst_n = 1'b1;
      edges(1);
      t_reset;
      t_fields;
      t_colour_debit;
      t_inactive;
      t_refill;
      t_period;
      t_floor;
      t_top;
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
   end
endmodule